// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block splits one instruction out of a six-byte fetch window that starts at the current program counter. The first byte carries two nibbles, an operation class and a variant selector. That byte alone sets how many bytes the instruction uses: 1, 2, 5 or 6. The decoder returns the register pair, the 32-bit constant word, the length and the address of the following instruction. Opcodes it does not recognise are flagged as invalid.

The block keeps its own program counter register. When `step` is high at a clock edge, the counter advances to the next sequential address. The fetch logic around the block supplies the window for the current counter value, so a stream of code can be walked one instruction per step. Byte 0 of the window sits in `win[7:0]`, byte 1 in `win[15:8]`, and so on up to byte 5 in `win[47:40]`.

Top module: `insn_splitter`

## Requirements
- R1: `icode` is the high nibble of window byte 0 and `ifun` is its low nibble. This holds even when the instruction is invalid.
- R2: Length depends on `icode`. Codes 0 (nop), 1 (halt) and 9 (return) take 1 byte. Codes 2 (reg move), 6 (arith/logic), A (push) and B (pop) take 2 bytes. Codes 7 (jump) and 8 (call) take 5 bytes. Codes 3 (immediate load), 4 (store) and 5 (load) take 6 bytes.
- R3: Codes 2–6, A and B have a register byte at window byte 1. `ra` is its high nibble and `rb` is its low nibble. For every other code, and for any invalid instruction, `ra` and `rb` both read 8, meaning no register.
- R4: `valc` is a little-endian 32-bit word, least significant byte first. It is read from window bytes 2–5 for codes 3, 4 and 5, and from bytes 1–4 for codes 7 and 8. For all other codes, and for any invalid instruction, it reads 0.
- R5: `bad` is 1 in each of these cases: `icode` above B; a nonzero `ifun` with a code other than 6 or 7; `ifun` above 3 with code 6; `ifun` above 6 with code 7. When `bad` is 1, `len` is 1.
- R6: `next_pc` equals `pc + len`, taken modulo 2^ADDR_W.
- R7: While `rst_n` is low, `pc` is held at RESET_PC.
- R8: When `step` is 1 at a rising edge, `pc` loads `next_pc`. When `step` is 0, `pc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | Advance the program counter to `next_pc` |
| win | input | 48 | Six fetched bytes; byte 0 is at the current `pc` |
| pc | output | ADDR_W | Current program counter |
| icode | output | 4 | Instruction code nibble |
| ifun | output | 4 | Function code nibble |
| ra | output | 4 | First register ID, or 8 for none |
| rb | output | 4 | Second register ID, or 8 for none |
| valc | output | 32 | Constant word |
| len | output | 3 | Instruction length in bytes |
| next_pc | output | ADDR_W | Address of the following instruction |
| bad | output | 1 | Invalid-instruction flag |

## Verification
The bench builds the block with ADDR_W = 8 and backs it with a 256-byte array that the bench holds. It then walks a program that covers every code class, every function-code limit and a run of invalid bytes that forces one-byte resynchronisation. A second instance has RESET_PC = 0xFC. It decodes a six-byte instruction that crosses the top of the address space, so the wrap of both `next_pc` and the constant window can be observed.

// File: rtl/insn_splitter.sv
module insn_splitter #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [47:0]       win,
  output logic [ADDR_W-1:0] pc,
  output logic [3:0]        icode,
  output logic [3:0]        ifun,
  output logic [3:0]        ra,
  output logic [3:0]        rb,
  output logic [31:0]       valc,
  output logic [2:0]        len,
  output logic [ADDR_W-1:0] next_pc,
  output logic              bad
);

  localparam logic [3:0] NO_REG = 4'h8;

  logic has_reg, has_c, c_late, fun_ok;

  assign icode = win[7:4];
  assign ifun  = win[3:0];

  always_comb begin
    has_reg = 1'b0;
    has_c   = 1'b0;
    c_late  = 1'b0;
    fun_ok  = (ifun == 4'h0);
    case (icode)
      4'h0, 4'h1, 4'h9: ;
      4'h2, 4'hA, 4'hB: has_reg = 1'b1;
      4'h6: begin has_reg = 1'b1; fun_ok = (ifun <= 4'h3); end
      4'h3, 4'h4, 4'h5: begin has_reg = 1'b1; has_c = 1'b1; c_late = 1'b1; end
      4'h7: begin has_c = 1'b1; fun_ok = (ifun <= 4'h6); end
      4'h8: has_c = 1'b1;
      default: fun_ok = 1'b0;
    endcase
  end

  assign bad = !fun_ok;

  assign len = bad ? 3'd1 : 3'd1 + {2'b00, has_reg} + (has_c ? 3'd4 : 3'd0);

  assign ra = (!bad && has_reg) ? win[15:12] : NO_REG;
  assign rb = (!bad && has_reg) ? win[11:8]  : NO_REG;

  assign valc = (bad || !has_c) ? 32'h0 : (c_late ? win[47:16] : win[39:8]);

  assign next_pc = pc + ADDR_W'(len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= RESET_PC;
    else if (step) pc <= next_pc;
  end

  assert_step_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pc == $past(next_pc));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc));

  assert_short_has_no_operands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (len == 3'd1) |-> (ra == NO_REG && rb == NO_REG && valc == 32'h0));

  assert_mem_forms_are_six_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && (icode == 4'h3 || icode == 4'h4 || icode == 4'h5)) |-> len == 3'd6);

  assert_unknown_code_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (icode > 4'hB) |-> (bad && len == 3'd1));

endmodule

// File: tb/tb_insn_splitter.sv
module tb_insn_splitter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic step_w = 1'b0;
  logic [7:0] mem [256];
  logic [47:0] win, win_w;
  logic [7:0] pc, next_pc, pc_w, next_pc_w;
  logic [3:0] icode, ifun, ra, rb, icode_w, ifun_w, ra_w, rb_w;
  logic [31:0] valc, valc_w;
  logic [2:0] len, len_w;
  logic bad, bad_w;
  int errors = 0;
  int checks = 0;
  logic [7:0] exp_pc;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 6; i++) begin
      win[8*i +: 8]   = mem[8'(pc + 8'(i))];
      win_w[8*i +: 8] = mem[8'(pc_w + 8'(i))];
    end
  end

  insn_splitter #(.ADDR_W(8), .RESET_PC(8'h00)) dut (
    .clk(clk), .rst_n(rst_n), .step(step), .win(win), .pc(pc), .icode(icode),
    .ifun(ifun), .ra(ra), .rb(rb), .valc(valc), .len(len), .next_pc(next_pc), .bad(bad));

  insn_splitter #(.ADDR_W(8), .RESET_PC(8'hFC)) dut_wrap (
    .clk(clk), .rst_n(rst_n), .step(step_w), .win(win_w), .pc(pc_w), .icode(icode_w),
    .ifun(ifun_w), .ra(ra_w), .rb(rb_w), .valc(valc_w), .len(len_w), .next_pc(next_pc_w), .bad(bad_w));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic one_step();
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
  endtask

  task automatic expect_insn(input logic [3:0] ic, input logic [3:0] fn, input logic [3:0] a,
                             input logic [3:0] b, input logic [31:0] c, input logic [2:0] l,
                             input logic x);
    chk("R8 pc", 32'(pc), 32'(exp_pc));
    chk("R1 icode", 32'(icode), 32'(ic));
    chk("R1 ifun", 32'(ifun), 32'(fn));
    chk("R3 ra", 32'(ra), 32'(a));
    chk("R3 rb", 32'(rb), 32'(b));
    chk("R4 valc", valc, c);
    chk("R2 len", 32'(len), 32'(l));
    chk("R5 bad", 32'(bad), 32'(x));
    chk("R6 next_pc", 32'(next_pc), 32'(8'(exp_pc + 8'(l))));
    exp_pc = 8'(exp_pc + 8'(l));
    one_step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R7 reset pc", 32'(pc), 32'h00);
    chk("R7 reset pc wrap inst", 32'(pc_w), 32'hFC);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 pc after release", 32'(pc), 32'h00);
    exp_pc = 8'h00;
  endtask

  task automatic t_program();
    expect_insn(4'h3, 4'h0, 4'h8, 4'h2, 32'h0000abcd, 3'd6, 1'b0);
    expect_insn(4'h2, 4'h0, 4'h4, 4'h3, 32'h0, 3'd2, 1'b0);
    expect_insn(4'h5, 4'h0, 4'h1, 4'h5, 32'hfffffff4, 3'd6, 1'b0);
    expect_insn(4'h4, 4'h0, 4'h6, 4'h4, 32'h0000041c, 3'd6, 1'b0);
    expect_insn(4'h6, 4'h1, 4'h2, 4'h3, 32'h0, 3'd2, 1'b0);
    expect_insn(4'h7, 4'h6, 4'h8, 4'h8, 32'h12345678, 3'd5, 1'b0);
    expect_insn(4'h8, 4'h0, 4'h8, 4'h8, 32'hddccbbaa, 3'd5, 1'b0);
    expect_insn(4'h9, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b0);
    expect_insn(4'hA, 4'h0, 4'h2, 4'h8, 32'h0, 3'd2, 1'b0);
    expect_insn(4'hB, 4'h0, 4'h3, 4'h8, 32'h0, 3'd2, 1'b0);
    expect_insn(4'h0, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b0);
    expect_insn(4'h1, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b0);
  endtask

  task automatic t_invalid();
    expect_insn(4'hC, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1);
    expect_insn(4'h2, 4'h1, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1);
    expect_insn(4'h1, 4'h1, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1);
    expect_insn(4'h6, 4'h4, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1);
    expect_insn(4'h0, 4'h1, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1);
    expect_insn(4'h7, 4'h7, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1);
    expect_insn(4'h0, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b0);
    expect_insn(4'hF, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1);
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    chk("R8 pc holds without step", 32'(pc), 32'(exp_pc));
  endtask

  task automatic t_wrap();
    @(negedge clk);
    chk("R4 wrap valc", valc_w, 32'h82302211);
    chk("R3 wrap rb", 32'(rb_w), 32'h7);
    chk("R2 wrap len", 32'(len_w), 32'd6);
    chk("R6 wrap next_pc", 32'(next_pc_w), 32'h02);
    step_w = 1'b1;
    @(negedge clk) step_w = 1'b0;
    chk("R8 wrap pc", 32'(pc_w), 32'h02);
  endtask

  task automatic t_reset_mid();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R7 pc back to reset", 32'(pc), 32'h00);
    chk("R7 wrap pc back to reset", 32'(pc_w), 32'hFC);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    begin
      logic [7:0] prog [48] = '{
        8'h30, 8'h82, 8'hcd, 8'hab, 8'h00, 8'h00,
        8'h20, 8'h43,
        8'h50, 8'h15, 8'hf4, 8'hff, 8'hff, 8'hff,
        8'h40, 8'h64, 8'h1c, 8'h04, 8'h00, 8'h00,
        8'h61, 8'h23,
        8'h76, 8'h78, 8'h56, 8'h34, 8'h12,
        8'h80, 8'haa, 8'hbb, 8'hcc, 8'hdd,
        8'h90, 8'ha0, 8'h28, 8'hb0, 8'h38, 8'h00, 8'h10,
        8'hc0, 8'h21, 8'h11, 8'h64, 8'h01, 8'h77, 8'h00, 8'hf0, 8'h00};
      for (int i = 0; i < 48; i++) mem[i] = prog[i];
    end
    mem[8'hFC] = 8'h30; mem[8'hFD] = 8'h87; mem[8'hFE] = 8'h11; mem[8'hFF] = 8'h22;
    t_reset();
    t_program();
    t_invalid();
    t_hold();
    t_wrap();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule